// File: doc/BRIEF.md
# Interrupt entry and return sequencer

This block is the control sequencer that carries a 16-bit processor into and out of interrupt service routines. At each instruction boundary it decides whether a pending device request outranks the level the processor is running at. If it does, the block saves the machine state on a supervisor stack and loads the handler address from a vector table. It also runs the return-from-interrupt instruction and unwinds that state. A return attempted in user mode is refused and becomes a privilege exception, which is entered in the same way as an interrupt.

The block holds the program counter, the processor status word, the stack pointer register and the two banked stack pointers, one for user mode and one for supervisor mode. All of its stack and table traffic goes through one single-port word memory. A write commits at the clock edge, and a read returns its data one cycle after the address is driven. While `busy_o` is high the processor is held. The fetch logic outside the block may rewrite the program counter between sequences.

Top module: `trap_sequencer`

## Requirements
- R1: After reset the status word is 16'h8005 (user mode, level 0, condition code field 3'b101), PC is 16'h3000, the stack pointer holds the user pointer 16'h0F00, and `busy_o`, `done_o` and `exc_o` are low.
- R2: A request is taken only in a cycle where `boundary_i` is high and the block is idle, and only if `irq_level_i` is strictly greater than status bits [10:8]. Otherwise `busy_o` stays low.
- R3: On entry from user mode (status bit 15 = 1), the stack pointer is copied to the saved user pointer and then reloaded from the saved supervisor pointer. On entry from supervisor mode the stack pointer is left as it is.
- R4: Entry writes the old status word to address SP-1 and then the PC to address SP-2, so the stack pointer ends two lower than it started. Each push decrements first and then writes.
- R5: After the pushes, status bit 15 becomes 0, bits [10:8] take the accepted level, bits [2:0] become 0, and all other bits are kept.
- R6: After entry, PC holds the memory word at address 16'h0100 plus the 8-bit vector. For example, vector 8'h80 reads address 16'h0180.
- R7: A return in supervisor mode reads the PC from address SP, then reads the status word from address SP+1, so the stack pointer ends two higher.
- R8: If the restored status bit 15 is 1, the stack pointer after the pops is saved as the supervisor pointer, and the stack pointer is reloaded from the saved user pointer.
- R9: A return requested in user mode pops nothing. It pulses `exc_o` for one cycle and performs an entry at the current level with vector 8'h00, which gives handler address 16'h0100.
- R10: Nested entries push below an existing frame on the same supervisor stack, and successive returns unwind the frames in reverse order.
- R11: When a return and a qualifying request arrive at the same boundary, the interrupt is entered and the return is not performed. When the request does not qualify, the return proceeds.
- R12: `done_o` pulses for exactly one cycle when each entry or return completes. The memory read and write enables are never both high, and both are low while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction boundary strobe, between store and next fetch |
| irq_valid_i | input | 1 | A device request is pending |
| irq_level_i | input | 3 | Priority level of the pending request |
| irq_vector_i | input | 8 | Vector of the pending request |
| rti_req_i | input | 1 | The instruction at this boundary is a return from interrupt |
| pc_wr_i | input | 1 | Fetch logic writes the PC while idle |
| pc_wdata_i | input | 16 | New PC value |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the address |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse when an entry or return completes |
| exc_o | output | 1 | One-cycle pulse when a privilege exception is taken |
| pc_o | output | 16 | Current PC |
| psr_o | output | 16 | Current status word |
| sp_o | output | 16 | Current stack pointer register |
| usp_o | output | 16 | Saved user stack pointer |
| ssp_o | output | 16 | Saved supervisor stack pointer |

## Verification
A return-from-interrupt request and a pending interrupt can arrive at the same instruction boundary, and both would start a sequence in the same cycle. The bench provokes this twice by raising `rti_req_i` and `irq_valid_i` in one strobe cycle. The first time, the request level is above the running level. The second time, it is not. Each case is judged by the stack pointer, the frame words left in the bench memory, and the resulting PC and status word: a new frame with the new handler address shows the interrupt won, and the popped PC and status show the return went ahead.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
    localparam int WORD_W   = 16;
    localparam int LVL_W    = 3;
    localparam int VEC_W    = 8;
    localparam int PRIV_BIT = 15;
    localparam int LVL_LO   = 8;
    localparam int LVL_HI   = LVL_LO + LVL_W - 1;
    localparam int CC_W     = 3;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_SR,
        ST_PUSH_PC,
        ST_VEC_RD,
        ST_VEC_LD,
        ST_POP_PC,
        ST_POP_SR,
        ST_RET_FIN
    } seq_state_e;

    typedef struct packed {
        seq_state_e        state;
        word_t             psr;
        word_t             pc;
        word_t             sp;
        word_t             usp;
        word_t             ssp;
        logic [LVL_W-1:0]  lvl;
        logic [VEC_W-1:0]  vec;
        logic              done;
        logic              exc;
    } seq_regs_t;
endpackage

// File: rtl/trap_accept.sv
module trap_accept #(
    parameter int LVL_W = 3
) (
    input  logic             boundary,
    input  logic             idle,
    input  logic             req_valid,
    input  logic [LVL_W-1:0] req_level,
    input  logic             ret_req,
    input  logic [LVL_W-1:0] cur_level,
    input  logic             user_mode,
    output logic             take_irq,
    output logic             take_exc,
    output logic             take_ret
);
    logic open_slot;
    logic outranks;

    always_comb begin
        open_slot = boundary && idle;
        outranks  = req_valid && (req_level > cur_level);
        take_irq  = open_slot && outranks;
        take_exc  = open_slot && !outranks && ret_req && user_mode;
        take_ret  = open_slot && !outranks && ret_req && !user_mode;
    end
endmodule

// File: rtl/trap_vec_addr.sv
module trap_vec_addr #(
    parameter int WORD_W = 16,
    parameter int VEC_W  = 8,
    parameter logic [WORD_W-1:0] TABLE_BASE = 16'h0100
) (
    input  logic [VEC_W-1:0]  vec,
    output logic [WORD_W-1:0] addr
);
    localparam int PAD_W = WORD_W - VEC_W;

    always_comb begin
        addr = TABLE_BASE + {{PAD_W{1'b0}}, vec};
    end
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
    import trap_seq_pkg::*;
#(
    parameter word_t             RESET_PSR  = 16'h8005,
    parameter word_t             RESET_PC   = 16'h3000,
    parameter word_t             RESET_SSP  = 16'h0300,
    parameter word_t             RESET_USP  = 16'h0F00,
    parameter word_t             TABLE_BASE = 16'h0100,
    parameter logic [VEC_W-1:0]  EXC_VEC    = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              irq_valid_i,
    input  logic [LVL_W-1:0]  irq_level_i,
    input  logic [VEC_W-1:0]  irq_vector_i,
    input  logic              rti_req_i,
    input  logic              pc_wr_i,
    input  logic [WORD_W-1:0] pc_wdata_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic [WORD_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              exc_o,
    output logic [WORD_W-1:0] pc_o,
    output logic [WORD_W-1:0] psr_o,
    output logic [WORD_W-1:0] sp_o,
    output logic [WORD_W-1:0] usp_o,
    output logic [WORD_W-1:0] ssp_o
);
    seq_regs_t r_q, r_d;

    logic  take_irq, take_exc, take_ret;
    word_t vec_addr;
    logic  idle;

    assign idle = (r_q.state == ST_IDLE);

    trap_accept #(.LVL_W(LVL_W)) u_accept (
        .boundary  (boundary_i),
        .idle      (idle),
        .req_valid (irq_valid_i),
        .req_level (irq_level_i),
        .ret_req   (rti_req_i),
        .cur_level (r_q.psr[LVL_HI:LVL_LO]),
        .user_mode (r_q.psr[PRIV_BIT]),
        .take_irq  (take_irq),
        .take_exc  (take_exc),
        .take_ret  (take_ret)
    );

    trap_vec_addr #(
        .WORD_W     (WORD_W),
        .VEC_W      (VEC_W),
        .TABLE_BASE (TABLE_BASE)
    ) u_vec (
        .vec  (r_q.vec),
        .addr (vec_addr)
    );

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.exc     = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        mem_we_o    = 1'b0;
        mem_re_o    = 1'b0;

        case (r_q.state)
            ST_IDLE: begin
                if (pc_wr_i) begin
                    r_d.pc = pc_wdata_i;
                end
                if (take_irq || take_exc) begin
                    r_d.lvl   = take_irq ? irq_level_i : r_q.psr[LVL_HI:LVL_LO];
                    r_d.vec   = take_irq ? irq_vector_i : EXC_VEC;
                    r_d.exc   = take_exc;
                    r_d.state = ST_PUSH_SR;
                    if (r_q.psr[PRIV_BIT]) begin
                        r_d.usp = r_q.sp;
                        r_d.sp  = r_q.ssp;
                    end
                end else if (take_ret) begin
                    r_d.state = ST_POP_PC;
                end
            end
            ST_PUSH_SR: begin
                mem_addr_o  = r_q.sp - 1'b1;
                mem_wdata_o = r_q.psr;
                mem_we_o    = 1'b1;
                r_d.sp      = r_q.sp - 1'b1;
                r_d.state   = ST_PUSH_PC;
            end
            ST_PUSH_PC: begin
                mem_addr_o  = r_q.sp - 1'b1;
                mem_wdata_o = r_q.pc;
                mem_we_o    = 1'b1;
                r_d.sp      = r_q.sp - 1'b1;
                r_d.psr[PRIV_BIT]      = 1'b0;
                r_d.psr[LVL_HI:LVL_LO] = r_q.lvl;
                r_d.psr[CC_W-1:0]      = '0;
                r_d.state   = ST_VEC_RD;
            end
            ST_VEC_RD: begin
                mem_addr_o = vec_addr;
                mem_re_o   = 1'b1;
                r_d.state  = ST_VEC_LD;
            end
            ST_VEC_LD: begin
                r_d.pc    = mem_rdata_i;
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
            ST_POP_PC: begin
                mem_addr_o = r_q.sp;
                mem_re_o   = 1'b1;
                r_d.sp     = r_q.sp + 1'b1;
                r_d.state  = ST_POP_SR;
            end
            ST_POP_SR: begin
                r_d.pc     = mem_rdata_i;
                mem_addr_o = r_q.sp;
                mem_re_o   = 1'b1;
                r_d.sp     = r_q.sp + 1'b1;
                r_d.state  = ST_RET_FIN;
            end
            ST_RET_FIN: begin
                r_d.psr = mem_rdata_i;
                if (mem_rdata_i[PRIV_BIT]) begin
                    r_d.ssp = r_q.sp;
                    r_d.sp  = r_q.usp;
                end
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.psr   <= RESET_PSR;
            r_q.pc    <= RESET_PC;
            r_q.sp    <= RESET_USP;
            r_q.usp   <= RESET_USP;
            r_q.ssp   <= RESET_SSP;
            r_q.lvl   <= '0;
            r_q.vec   <= '0;
            r_q.done  <= 1'b0;
            r_q.exc   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = !idle;
    assign done_o = r_q.done;
    assign exc_o  = r_q.exc;
    assign pc_o   = r_q.pc;
    assign psr_o  = r_q.psr;
    assign sp_o   = r_q.sp;
    assign usp_o  = r_q.usp;
    assign ssp_o  = r_q.ssp;
endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        boundary_i,
    input logic        irq_valid_i,
    input logic [2:0]  irq_level_i,
    input logic        rti_req_i,
    input logic [15:0] mem_addr_o,
    input logic        mem_we_o,
    input logic        mem_re_o,
    input logic        busy_o,
    input logic        done_o,
    input logic        exc_o,
    input logic [15:0] psr_o,
    input logic [15:0] sp_o
);
    assert_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !boundary_i) |=> !busy_o);

    assert_low_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && boundary_i && irq_valid_i && !rti_req_i
         && (irq_level_i <= psr_o[10:8])) |=> !busy_o);

    assert_push_below_sp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_addr_o == sp_o - 16'd1));

    assert_push_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_o) |=> (mem_we_o && mem_addr_o == $past(mem_addr_o) - 16'd1));

    assert_exc_from_user_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> (psr_o[15] && busy_o && !mem_re_o));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(mem_we_o || mem_re_o));

    assert_rw_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o));
endmodule

bind trap_sequencer trap_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .boundary_i  (boundary_i),
    .irq_valid_i (irq_valid_i),
    .irq_level_i (irq_level_i),
    .rti_req_i   (rti_req_i),
    .mem_addr_o  (mem_addr_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .exc_o       (exc_o),
    .psr_o       (psr_o),
    .sp_o        (sp_o)
);

// File: tb/tb_trap_sequencer.sv
module tb_trap_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary_i = 1'b0;
    logic        irq_valid_i = 1'b0;
    logic [2:0]  irq_level_i = '0;
    logic [7:0]  irq_vector_i = '0;
    logic        rti_req_i = 1'b0;
    logic        pc_wr_i = 1'b0;
    logic [15:0] pc_wdata_i = '0;
    logic [15:0] mem_rdata_i;
    logic [15:0] mem_addr_o, mem_wdata_o;
    logic        mem_we_o, mem_re_o, busy_o, done_o, exc_o;
    logic [15:0] pc_o, psr_o, sp_o, usp_o, ssp_o;

    int checks = 0;
    int errors = 0;
    bit exc_seen;

    logic [15:0] mem [0:1023];

    always #10 clk = ~clk;

    trap_sequencer dut (.*);

    always @(posedge clk) begin
        if (!rst_n) begin
            mem[10'h100] <= 16'h7000;
            mem[10'h180] <= 16'h6200;
            mem[10'h1A0] <= 16'h6300;
            mem[10'h1C0] <= 16'h6400;
        end else if (mem_we_o) begin
            mem[mem_addr_o[9:0]] <= mem_wdata_o;
        end
        mem_rdata_i <= mem[mem_addr_o[9:0]];
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_pc(input logic [15:0] v);
        @(negedge clk);
        pc_wr_i = 1'b1; pc_wdata_i = v;
        @(negedge clk);
        pc_wr_i = 1'b0;
    endtask

    task automatic strobe(input bit iv, input logic [2:0] lv, input logic [7:0] vc, input bit rt);
        @(negedge clk);
        boundary_i = 1'b1; irq_valid_i = iv; irq_level_i = lv;
        irq_vector_i = vc; rti_req_i = rt;
        @(negedge clk);
        boundary_i = 1'b0; irq_valid_i = 1'b0; rti_req_i = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        bit got = 0;
        exc_seen = 0;
        for (int i = 0; i < 20 && !got; i++) begin
            if (exc_o) exc_seen = 1;
            if (done_o) got = 1;
            else @(negedge clk);
        end
        chk({tag, " done seen"}, {15'd0, got}, 16'd1);
    endtask

    task automatic t_reset;
        chk("R1 psr", psr_o, 16'h8005);
        chk("R1 pc", pc_o, 16'h3000);
        chk("R1 sp", sp_o, 16'h0F00);
        chk("R1 idle outs", {13'd0, busy_o, done_o, exc_o}, 16'd0);
    endtask

    task automatic t_reject_user;
        @(negedge clk);
        irq_valid_i = 1'b1; irq_level_i = 3'd5; irq_vector_i = 8'h80;
        repeat (3) @(negedge clk);
        chk("R2 no strobe no accept", {15'd0, busy_o}, 16'd0);
        irq_valid_i = 1'b0;
        strobe(1'b1, 3'd0, 8'h80, 1'b0);
        chk("R2 equal level rejected", {15'd0, busy_o}, 16'd0);
        chk("R2 sp untouched", sp_o, 16'h0F00);
    endtask

    task automatic t_user_entry;
        set_pc(16'h3007);
        strobe(1'b1, 3'd4, 8'h80, 1'b0);
        wait_done("R6 entry");
        chk("R3 usp saved", usp_o, 16'h0F00);
        chk("R4 sp minus two", sp_o, 16'h02FE);
        chk("R4 psr pushed first", mem[10'h2FF], 16'h8005);
        chk("R4 pc pushed second", mem[10'h2FE], 16'h3007);
        chk("R5 new psr", psr_o, 16'h0400);
        chk("R6 handler pc", pc_o, 16'h6200);
        @(negedge clk);
        chk("R12 done one cycle", {15'd0, done_o}, 16'd0);
    endtask

    task automatic t_nested;
        strobe(1'b1, 3'd4, 8'hA0, 1'b0);
        chk("R2 equal level in isr rejected", {15'd0, busy_o}, 16'd0);
        set_pc(16'h6203);
        strobe(1'b1, 3'd6, 8'hA0, 1'b0);
        wait_done("R10 nested");
        chk("R3 supervisor no swap usp", usp_o, 16'h0F00);
        chk("R10 sp below frame", sp_o, 16'h02FC);
        chk("R10 psr frame", mem[10'h2FD], 16'h0400);
        chk("R10 pc frame", mem[10'h2FC], 16'h6203);
        chk("R5 nested psr", psr_o, 16'h0600);
        chk("R6 nested pc", pc_o, 16'h6300);
    endtask

    task automatic t_same_boundary;
        set_pc(16'h6310);
        strobe(1'b1, 3'd7, 8'hC0, 1'b1);
        wait_done("R11 irq wins");
        chk("R11 irq wins sp", sp_o, 16'h02FA);
        chk("R11 irq wins frame pc", mem[10'h2FA], 16'h6310);
        chk("R11 irq wins psr", psr_o, 16'h0700);
        chk("R11 irq wins pc", pc_o, 16'h6400);
        strobe(1'b0, 3'd0, 8'h00, 1'b1);
        wait_done("R7 return");
        chk("R7 pc popped", pc_o, 16'h6310);
        chk("R7 psr popped", psr_o, 16'h0600);
        chk("R7 sp plus two", sp_o, 16'h02FC);
        strobe(1'b1, 3'd3, 8'hC0, 1'b1);
        wait_done("R11 rti proceeds");
        chk("R11 rti proceeds pc", pc_o, 16'h6203);
        chk("R11 rti proceeds psr", psr_o, 16'h0400);
        chk("R10 unwind sp", sp_o, 16'h02FE);
    endtask

    task automatic t_return_user;
        strobe(1'b0, 3'd0, 8'h00, 1'b1);
        wait_done("R8 to user");
        chk("R8 pc", pc_o, 16'h3007);
        chk("R8 psr", psr_o, 16'h8005);
        chk("R8 ssp saved", ssp_o, 16'h0300);
        chk("R8 sp from usp", sp_o, 16'h0F00);
    endtask

    task automatic t_user_rti;
        set_pc(16'h3050);
        strobe(1'b0, 3'd0, 8'h00, 1'b1);
        wait_done("R9 exception");
        chk("R9 exc pulse", {15'd0, exc_seen}, 16'd1);
        chk("R9 usp", usp_o, 16'h0F00);
        chk("R9 sp pushes only", sp_o, 16'h02FE);
        chk("R9 psr frame", mem[10'h2FF], 16'h8005);
        chk("R9 pc frame", mem[10'h2FE], 16'h3050);
        chk("R9 psr level kept", psr_o, 16'h0000);
        chk("R9 handler", pc_o, 16'h7000);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reject_user();
        t_user_entry();
        t_nested();
        t_same_boundary();
        t_return_user();
        t_user_rti();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule